// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command-register state machine of a byte-wide parallel flash device with a 17-bit address. It watches the write cycles on the device bus, takes the address and data at the falling edge of the write-enable strobe, and matches them against the multi-write unlock sequences that guard every command. A completed sequence produces a one-cycle request to the rest of the chip. The request is one of: return to read mode, enter the identifier (autoselect) mode, program one byte, erase the whole chip, or erase one sector. Each request comes with the address, data or sector number it needs.

The block runs on the system clock. The write-enable input is synchronised and its falling edge is detected inside the block. While the external program/erase engine reports busy, the block ignores bus writes. It also reports whether array reads currently return array data or identifier data.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After the asynchronous active-low reset, autoselMode is 0 (read-array mode) and no request strobe is high.
- R2: Every command starts with data AAh to address 5555h, then data 55h to address 2AAAh. Any write that does not match the pair expected at its step returns the sequence to idle, issues no request and leaves autoselMode unchanged.
- R3: Data F0h written to 5555h as the third write raises resetPulse for one cycle and clears autoselMode to 0.
- R4: Data 90h written to 5555h as the third write raises autoselPulse for one cycle and sets autoselMode to 1.
- R5: Data A0h written to 5555h as the third write makes the next write, at any address and with any data, raise progPulse for one cycle. progAddr then holds all 17 address bits of that write and progData holds its data.
- R6: Data 80h written to 5555h as the third write, then AAh to 5555h, then 55h to 2AAAh, then 10h to 5555h raises chipErasePulse for one cycle. Data 10h written to any other address as the sixth write aborts with no request.
- R7: The same five-write prefix followed by data 30h at any address raises sectorErasePulse for one cycle, with sectorNum equal to address bits 16 down to 14 of that write.
- R8: Address bits 16 and 15 are ignored when the address of an unlock or command write is compared.
- R9: While engineBusy is high at the falling edge of the write strobe, that write is ignored and does not advance or abort the sequence.
- R10: At most one request strobe is high in any cycle, and each strobe is high for one cycle. progAddr, progData and sectorNum change only together with their own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| weN | input | 1 | Bus write strobe, active low, asynchronous to clk |
| addrIn | input | 17 | Bus address |
| dataIn | input | 8 | Bus write data |
| engineBusy | input | 1 | High while a program or erase is running |
| resetPulse | output | 1 | Return-to-read request |
| autoselPulse | output | 1 | Enter-identifier-mode request |
| progPulse | output | 1 | Byte program request |
| chipErasePulse | output | 1 | Whole-chip erase request |
| sectorErasePulse | output | 1 | Sector erase request |
| progAddr | output | 17 | Address of the last program request |
| progData | output | 8 | Data of the last program request |
| sectorNum | output | 3 | Sector of the last sector erase request |
| autoselMode | output | 1 | 1 while in identifier mode, 0 in read-array mode |

## Verification
On every cycle the assertions check that the request strobes are exclusive and last one cycle, and that the mode bit moves only together with the strobe that sets or clears it. They also check that the latched fields change only with their strobe and that no strobe follows a busy write edge. Only the bench scenarios can show that each full sequence yields the right request and fields. The same holds for the effect of a wrong pair at each step, the masking of the high address bits, and the sixth-write choice between the two erase kinds.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int DATA_W = 8;
  localparam int CMP_W  = 15;

  localparam logic [CMP_W-1:0] UNLOCK_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] UNLOCK_ADDR_B = 15'h2AAA;

  localparam logic [DATA_W-1:0] KEY_A      = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_B      = 8'h55;
  localparam logic [DATA_W-1:0] OP_RESET   = 8'hF0;
  localparam logic [DATA_W-1:0] OP_AUTOSEL = 8'h90;
  localparam logic [DATA_W-1:0] OP_PROG    = 8'hA0;
  localparam logic [DATA_W-1:0] OP_ERASE   = 8'h80;
  localparam logic [DATA_W-1:0] OP_CHIP    = 8'h10;
  localparam logic [DATA_W-1:0] OP_SECTOR  = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERS1, ST_ERS2, ST_ERS3
  } cmdState_t;

  typedef struct packed {
    logic              valid;
    logic              atAddrA;
    logic              atAddrB;
    logic [DATA_W-1:0] data;
  } wrInfo_t;

  typedef struct packed {
    logic latchProg;
    logic latchSector;
  } ctlStrobes_t;
endpackage

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SECT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              engineBusy,
  input  ctlStrobes_t       ctl,
  output wrInfo_t           wrInfo,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic [SECT_W-1:0] sectorNum
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  logic [SYNC_STAGES:0] syncQ;
  logic                 weFall;
  logic [ADDR_W-1:0]    capAddr;
  logic [DATA_W-1:0]    capData;
  logic                 capValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], weN};
  end

  assign weFall = syncQ[SYNC_STAGES] & ~syncQ[SYNC_STAGES-1] & ~engineBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr  <= '0;
      capData  <= '0;
      capValid <= 1'b0;
    end else begin
      capValid <= weFall;
      if (weFall) begin
        capAddr <= addrIn;
        capData <= dataIn;
      end
    end
  end

  always_comb begin
    wrInfo.valid   = capValid;
    wrInfo.atAddrA = (capAddr[CMP_W-1:0] == UNLOCK_ADDR_A);
    wrInfo.atAddrB = (capAddr[CMP_W-1:0] == UNLOCK_ADDR_B);
    wrInfo.data    = capData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progAddr  <= '0;
      progData  <= '0;
      sectorNum <= '0;
    end else begin
      if (ctl.latchProg) begin
        progAddr <= capAddr;
        progData <= capData;
      end
      if (ctl.latchSector) sectorNum <= capAddr[ADDR_W-1:SECT_LSB];
    end
  end
endmodule

// File: rtl/fcd_control.sv
module fcd_control
  import fcd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  wrInfo_t     wrInfo,
  output ctlStrobes_t ctl,
  output logic        resetPulse,
  output logic        autoselPulse,
  output logic        progPulse,
  output logic        chipErasePulse,
  output logic        sectorErasePulse,
  output logic        autoselMode
);
  cmdState_t state, stateNxt;
  logic      doReset, doAutosel, doProg, doChip, doSector;
  logic      pairA, pairB;

  assign pairA = wrInfo.atAddrA && (wrInfo.data == KEY_A);
  assign pairB = wrInfo.atAddrB && (wrInfo.data == KEY_B);

  always_comb begin
    stateNxt  = state;
    doReset   = 1'b0;
    doAutosel = 1'b0;
    doProg    = 1'b0;
    doChip    = 1'b0;
    doSector  = 1'b0;
    if (wrInfo.valid) begin
      stateNxt = ST_IDLE;
      unique case (state)
        ST_IDLE: if (pairA) stateNxt = ST_UNL1;
        ST_UNL1: if (pairB) stateNxt = ST_UNL2;
        ST_UNL2: if (wrInfo.atAddrA) begin
          unique case (wrInfo.data)
            OP_RESET:   doReset   = 1'b1;
            OP_AUTOSEL: doAutosel = 1'b1;
            OP_PROG:    stateNxt  = ST_PROG;
            OP_ERASE:   stateNxt  = ST_ERS1;
            default:    stateNxt  = ST_IDLE;
          endcase
        end
        ST_PROG: doProg = 1'b1;
        ST_ERS1: if (pairA) stateNxt = ST_ERS2;
        ST_ERS2: if (pairB) stateNxt = ST_ERS3;
        ST_ERS3: begin
          if (wrInfo.data == OP_SECTOR)                        doSector = 1'b1;
          else if (wrInfo.data == OP_CHIP && wrInfo.atAddrA)   doChip   = 1'b1;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  assign ctl.latchProg   = doProg;
  assign ctl.latchSector = doSector;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state            <= ST_IDLE;
      resetPulse       <= 1'b0;
      autoselPulse     <= 1'b0;
      progPulse        <= 1'b0;
      chipErasePulse   <= 1'b0;
      sectorErasePulse <= 1'b0;
      autoselMode      <= 1'b0;
    end else begin
      state            <= stateNxt;
      resetPulse       <= doReset;
      autoselPulse     <= doAutosel;
      progPulse        <= doProg;
      chipErasePulse   <= doChip;
      sectorErasePulse <= doSector;
      if (doReset)        autoselMode <= 1'b0;
      else if (doAutosel) autoselMode <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SECT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              engineBusy,
  output logic              resetPulse,
  output logic              autoselPulse,
  output logic              progPulse,
  output logic              chipErasePulse,
  output logic              sectorErasePulse,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic [SECT_W-1:0] sectorNum,
  output logic              autoselMode
);
  wrInfo_t     wrInfo;
  ctlStrobes_t ctl;

  fcd_datapath #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .weN(weN), .addrIn(addrIn), .dataIn(dataIn),
    .engineBusy(engineBusy), .ctl(ctl), .wrInfo(wrInfo),
    .progAddr(progAddr), .progData(progData), .sectorNum(sectorNum)
  );

  fcd_control i_ctl (
    .clk(clk), .rstN(rstN), .wrInfo(wrInfo), .ctl(ctl),
    .resetPulse(resetPulse), .autoselPulse(autoselPulse), .progPulse(progPulse),
    .chipErasePulse(chipErasePulse), .sectorErasePulse(sectorErasePulse),
    .autoselMode(autoselMode)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        weN,
  input logic [16:0] addrIn,
  input logic [7:0]  dataIn,
  input logic        engineBusy,
  input logic        resetPulse,
  input logic        autoselPulse,
  input logic        progPulse,
  input logic        chipErasePulse,
  input logic        sectorErasePulse,
  input logic [16:0] progAddr,
  input logic [7:0]  progData,
  input logic [2:0]  sectorNum,
  input logic        autoselMode
);
  logic [4:0] pulses;
  assign pulses = {resetPulse, autoselPulse, progPulse, chipErasePulse, sectorErasePulse};

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulses));

  // R10
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulses != 5'b0) |=> (pulses == 5'b0));

  // R4
  mode_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(autoselMode) |-> autoselPulse);

  // R3
  mode_leave_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(autoselMode) |-> resetPulse);

  // R5
  prog_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(progAddr) || !$stable(progData)) |-> progPulse);

  // R7
  sector_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sectorNum) |-> sectorErasePulse);

  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulses != 5'b0) |-> !$past(engineBusy, 2));
endmodule

bind flash_cmd_decoder fcd_checker i_fcd_checker (.*);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        weN = 1'b1;
  logic [16:0] addrIn = '0;
  logic [7:0]  dataIn = '0;
  logic        engineBusy = 1'b0;
  logic        resetPulse, autoselPulse, progPulse, chipErasePulse, sectorErasePulse;
  logic [16:0] progAddr;
  logic [7:0]  progData;
  logic [2:0]  sectorNum;
  logic        autoselMode;

  int checks = 0;
  int failures = 0;
  int nReset = 0, nAuto = 0, nProg = 0, nChip = 0, nSect = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (.*);

  always @(negedge clk) begin
    if (rstN) begin
      nReset += int'(resetPulse);
      nAuto  += int'(autoselPulse);
      nProg  += int'(progPulse);
      nChip  += int'(chipErasePulse);
      nSect  += int'(sectorErasePulse);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [16:0] a, logic [7:0] d);
    @(negedge clk);
    addrIn = a; dataIn = d; weN = 1'b0;
    repeat (5) @(negedge clk);
    weN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic unlock(logic [16:0] a1, logic [16:0] a2);
    busWrite(a1, 8'hAA);
    busWrite(a2, 8'h55);
  endtask

  task automatic totals(string req, int r, int a, int p, int c, int s);
    check({req, " reset"}, nReset, r);
    check({req, " autosel"}, nAuto, a);
    check({req, " prog"}, nProg, p);
    check({req, " chip"}, nChip, c);
    check({req, " sector"}, nSect, s);
  endtask

  task automatic testResetState();
    check("R1 mode", int'(autoselMode), 0);
    check("R1 strobes", int'({resetPulse, autoselPulse, progPulse, chipErasePulse, sectorErasePulse}), 0);
    totals("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic testAutoselAndReset();
    unlock(17'h05555, 17'h02AAA);
    busWrite(17'h05555, 8'h90);
    check("R4 mode", int'(autoselMode), 1);
    totals("R4", 0, 1, 0, 0, 0);
    unlock(17'h05555, 17'h02AAA);
    busWrite(17'h05555, 8'hF0);
    check("R3 mode", int'(autoselMode), 0);
    totals("R3", 1, 1, 0, 0, 0);
  endtask

  task automatic testProgram();
    unlock(17'h05555, 17'h02AAA);
    busWrite(17'h05555, 8'hA0);
    totals("R5 before data", 1, 1, 0, 0, 0);
    busWrite(17'h1C3A5, 8'h5A);
    totals("R5", 1, 1, 1, 0, 0);
    check("R5 addr", int'(progAddr), 'h1C3A5);
    check("R5 data", int'(progData), 'h5A);
  endtask

  task automatic testHighBitsIgnored();
    unlock(17'h1D555, 17'h0AAAA);
    busWrite(17'h15555, 8'h90);
    check("R8 mode", int'(autoselMode), 1);
    totals("R8", 1, 2, 1, 0, 0);
  endtask

  task automatic testMismatch();
    // wrong second-step data, then a command write: no request, mode stays 1
    busWrite(17'h05555, 8'hAA);
    busWrite(17'h02AAA, 8'h54);
    busWrite(17'h05555, 8'hF0);
    check("R2 mode kept", int'(autoselMode), 1);
    // wrong first-step address
    busWrite(17'h05554, 8'hAA);
    busWrite(17'h02AAA, 8'h55);
    busWrite(17'h05555, 8'hF0);
    // unknown command code
    unlock(17'h05555, 17'h02AAA);
    busWrite(17'h05555, 8'h77);
    busWrite(17'h05555, 8'hF0);
    check("R2 mode kept2", int'(autoselMode), 1);
    totals("R2", 1, 2, 1, 0, 0);
    // recovery: a clean sequence still works
    unlock(17'h05555, 17'h02AAA);
    busWrite(17'h05555, 8'hF0);
    check("R2 recover mode", int'(autoselMode), 0);
    totals("R2 recover", 2, 2, 1, 0, 0);
  endtask

  task automatic erasePrefix();
    unlock(17'h05555, 17'h02AAA);
    busWrite(17'h05555, 8'h80);
    unlock(17'h05555, 17'h02AAA);
  endtask

  task automatic testErase();
    erasePrefix();
    busWrite(17'h05555, 8'h10);
    totals("R6", 2, 2, 1, 1, 0);
    erasePrefix();
    busWrite(17'h01234, 8'h10);
    totals("R6 wrong addr", 2, 2, 1, 1, 0);
    erasePrefix();
    busWrite(17'h1C000, 8'h30);
    totals("R7", 2, 2, 1, 1, 1);
    check("R7 sector7", int'(sectorNum), 7);
    erasePrefix();
    busWrite(17'h0A123, 8'h30);
    check("R7 sector2", int'(sectorNum), 2);
    totals("R7 b", 2, 2, 1, 1, 2);
    check("R10 prog fields kept", int'(progAddr), 'h1C3A5);
  endtask

  task automatic testBusy();
    engineBusy = 1'b1;
    unlock(17'h05555, 17'h02AAA);
    busWrite(17'h05555, 8'hA0);
    busWrite(17'h00011, 8'h22);
    totals("R9 busy", 2, 2, 1, 1, 2);
    check("R9 addr kept", int'(progAddr), 'h1C3A5);
    // busy write in the middle must not abort the sequence
    engineBusy = 1'b0;
    unlock(17'h05555, 17'h02AAA);
    engineBusy = 1'b1;
    busWrite(17'h00000, 8'h00);
    engineBusy = 1'b0;
    busWrite(17'h05555, 8'h90);
    check("R9 mid mode", int'(autoselMode), 1);
    totals("R9 mid", 2, 3, 1, 1, 2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testResetState();
    testAutoselAndReset();
    testProgram();
    testHighBitsIgnored();
    testMismatch();
    testErase();
    testBusy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule